// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Unit

This block holds the hazard logic of an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. It is purely combinational. Each cycle it looks at the register numbers and write enables that the pipeline registers carry and decides three things. The first is where each execute-stage ALU operand comes from: the register file, the memory-stage result or the writeback-stage result. The second is whether a load that is followed at once by a consumer of its data must hold fetch and decode for one cycle while a bubble goes into execute. The third is whether a taken branch or jump resolved in execute must clear the two instructions that were fetched after it.

The surrounding datapath uses the outputs directly. The forward selects drive the operand multiplexers. The stall outputs act as active-high hold enables on the PC and the decode register. The flush outputs act as synchronous clears on the decode and execute registers. The register file either writes in the first half of the cycle or passes its write data through to its reads. Because of this, a dependency from writeback to decode never needs a stall and is not handled here.

Top module: `hz_unit`

## Requirements
- R1: An operand select (`fwd_a` for the first execute source, `fwd_b` for the second) is 2'b10 (take the memory-stage result) when `m_wen` is 1, `m_rd` equals that source and the source is not register 0.
- R2: An operand select is 2'b01 (take the writeback result) when `w_wen` is 1, `w_rd` equals that source, the source is not register 0 and R1 does not apply.
- R3: When the memory stage and the writeback stage both match a source, the select is 2'b10, because the newer memory-stage value wins.
- R4: A source of register 0 always gives the select 2'b00, whatever the destinations and enables are.
- R5: In every other case an operand select is 2'b00 (register file). The code 2'b11 never appears, and each operand is decided from its own source number only.
- R6: When `e_is_load` is 1 and `e_rd` equals `d_rs1` or `d_rs2`, the outputs `stall_f`, `stall_d` and `flush_e` are all 1. This holds fetch and decode and puts a bubble into execute.
- R7: When `e_is_load` is 0, or `e_rd` matches neither decode source, `stall_f` and `stall_d` are 0.
- R8: When `e_redirect` is 1, `flush_d` and `flush_e` are both 1. `flush_d` is 1 only on a redirect, and `flush_e` is 1 only on a redirect or a load-use stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_rs1 | input | 5 | First source register of the decode-stage instruction |
| d_rs2 | input | 5 | Second source register of the decode-stage instruction |
| e_rs1 | input | 5 | First source register of the execute-stage instruction |
| e_rs2 | input | 5 | Second source register of the execute-stage instruction |
| e_rd | input | 5 | Destination register of the execute-stage instruction |
| e_is_load | input | 1 | Execute-stage instruction reads data memory into e_rd |
| e_redirect | input | 1 | Taken branch or jump resolved in execute |
| m_rd | input | 5 | Destination register of the memory-stage instruction |
| m_wen | input | 1 | Memory-stage instruction writes the register file |
| w_rd | input | 5 | Destination register of the writeback-stage instruction |
| w_wen | input | 1 | Writeback-stage instruction writes the register file |
| fwd_a | output | 2 | Select for the first ALU operand: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Select for the second ALU operand, same encoding |
| stall_f | output | 1 | Hold the PC register |
| stall_d | output | 1 | Hold the decode pipeline register |
| flush_d | output | 1 | Clear the decode pipeline register |
| flush_e | output | 1 | Clear the execute pipeline register |

## Verification
The bench sweeps every combination of a small set of register numbers (registers 0 to 3) for sources and destinations, with every setting of the enables, and computes the expected selects and stall or flush outputs from the rules above. The main targets are a double match in memory and writeback, where a design with the priority reversed would feed the ALU a stale value, and a source of register 0 with matching destinations, where a design without the zero guard would forward a value that was never architecturally written. It also covers load-use matches on the second decode source and loads into a register nobody reads. A design that compares only one source would miss a stall, and one that ignores the load flag would stall on ordinary ALU results. Redirects with and without a load in execute check that the decode clear follows only the redirect.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] m_rd,
  input  logic          m_wen,
  input  logic [AW-1:0] w_rd,
  input  logic          w_wen,
  output fwd_sel_e      sel
);

  logic src_nz;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_nz  = (src != '0);
    mem_hit = m_wen && src_nz && (m_rd == src);
    wb_hit  = w_wen && src_nz && (w_rd == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // The memory stage holds the newer value, so it must win a double match
  always_comb begin
    if (mem_hit && wb_hit) begin
      p_mem_over_wb_r3: assert (sel == FWD_MEM);
    end
    if (!src_nz) begin
      p_zero_src_r4: assert (sel == FWD_RF);
    end
  end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic [AW-1:0] e_rd,
  input  logic          e_is_load,
  output logic          lw_stall
);

  logic hit1;
  logic hit2;

  always_comb begin
    hit1     = (e_rd == d_rs1);
    hit2     = (e_rd == d_rs2);
    lw_stall = e_is_load && (hit1 || hit2);
  end

  always_comb begin
    if (!e_is_load) begin
      p_no_stall_without_load_r7: assert (!lw_stall);
    end
  end

endmodule

// File: rtl/hz_flush_ctl.sv
module hz_flush_ctl (
  input  logic lw_stall,
  input  logic e_redirect,
  output logic stall_f,
  output logic stall_d,
  output logic flush_d,
  output logic flush_e
);

  always_comb begin
    stall_f = lw_stall;
    stall_d = lw_stall;
    flush_d = e_redirect;
    flush_e = e_redirect || lw_stall;
  end

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] d_rs1,
  input  logic [AW-1:0] d_rs2,
  input  logic [AW-1:0] e_rs1,
  input  logic [AW-1:0] e_rs2,
  input  logic [AW-1:0] e_rd,
  input  logic          e_is_load,
  input  logic          e_redirect,
  input  logic [AW-1:0] m_rd,
  input  logic          m_wen,
  input  logic [AW-1:0] w_rd,
  input  logic          w_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall_f,
  output logic          stall_d,
  output logic          flush_d,
  output logic          flush_e
);

  localparam int unsigned NSRC = 2;

  logic [AW-1:0] e_src [NSRC];
  fwd_sel_e      sel   [NSRC];
  logic          lw_stall;

  always_comb begin
    e_src[0] = e_rs1;
    e_src[1] = e_rs2;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    hz_fwd_sel #(.AW(AW)) u_sel (
      .src   (e_src[g]),
      .m_rd  (m_rd),
      .m_wen (m_wen),
      .w_rd  (w_rd),
      .w_wen (w_wen),
      .sel   (sel[g])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hz_load_use #(.AW(AW)) u_lu (
    .d_rs1     (d_rs1),
    .d_rs2     (d_rs2),
    .e_rd      (e_rd),
    .e_is_load (e_is_load),
    .lw_stall  (lw_stall)
  );

  hz_flush_ctl u_fl (
    .lw_stall   (lw_stall),
    .e_redirect (e_redirect),
    .stall_f    (stall_f),
    .stall_d    (stall_d),
    .flush_d    (flush_d),
    .flush_e    (flush_e)
  );

  // Output relations between the separately built pieces
  always_comb begin
    p_sel_legal_r5: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    p_stall_pair_r6: assert (stall_f == stall_d);
    if (stall_d) begin
      p_bubble_on_stall_r6: assert (flush_e);
    end
    if (e_redirect) begin
      p_redirect_clears_r8: assert (flush_d && flush_e);
    end
    if (flush_d) begin
      p_flush_d_cause_r8: assert (e_redirect);
    end
  end

endmodule

// File: tb/hz_unit_bench.sv
module hz_unit_bench;

  localparam int AW = 5;

  logic clk;
  logic [AW-1:0] d_rs1, d_rs2, e_rs1, e_rs2, e_rd, m_rd, w_rd;
  logic e_is_load, e_redirect, m_wen, w_wen;
  logic [1:0] fwd_a, fwd_b;
  logic stall_f, stall_d, flush_d, flush_e;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  initial clk = 0;
  always #5 clk = ~clk;

  hz_unit #(.AW(AW)) u_hz_unit (
    .d_rs1(d_rs1), .d_rs2(d_rs2), .e_rs1(e_rs1), .e_rs2(e_rs2),
    .e_rd(e_rd), .e_is_load(e_is_load), .e_redirect(e_redirect),
    .m_rd(m_rd), .m_wen(m_wen), .w_rd(w_rd), .w_wen(w_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall_f(stall_f), .stall_d(stall_d),
    .flush_d(flush_d), .flush_e(flush_e)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(input int src, input int mr, input int mw,
                                 input int wr, input int ww);
    if (src == 0) return 0;
    if (mw == 1 && mr == src) return 2;
    if (ww == 1 && wr == src) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input int src, input int mr, input int mw,
                                    input int wr, input int ww);
    if (src == 0) return "R4";
    if (mw == 1 && mr == src && ww == 1 && wr == src) return "R3";
    if (mw == 1 && mr == src) return "R1";
    if (ww == 1 && wr == src) return "R2";
    return "R5";
  endfunction

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    d_rs1 = '0; d_rs2 = '0; e_rs1 = '0; e_rs2 = '0; e_rd = '0;
    m_rd = '0; w_rd = '0; e_is_load = 0; e_redirect = 0; m_wen = 0; w_wen = 0;
    settle();
    // Idle pipeline: nothing forwarded, stalled or flushed
    chk("R5 idle fwd_a", fwd_a, 0);
    chk("R5 idle fwd_b", fwd_b, 0);
    chk("R7 idle stall_f", stall_f, 0);
    chk("R8 idle flush_d", flush_d, 0);
    chk("R8 idle flush_e", flush_e, 0);

    // Forwarding sweep: R1 R2 R3 R4 R5
    for (int s = 0; s < 4; s++)
      for (int mr = 0; mr < 4; mr++)
        for (int wr = 0; wr < 4; wr++)
          for (int en = 0; en < 4; en++) begin
            int s2;
            s2 = (s * 3 + 1) % 4;
            e_rs1 = AW'(s); e_rs2 = AW'(s2);
            m_rd = AW'(mr); w_rd = AW'(wr);
            m_wen = en[0]; w_wen = en[1];
            settle();
            chk(sel_tag(s, mr, en & 1, wr, en >> 1), fwd_a,
                exp_sel(s, mr, en & 1, wr, en >> 1));
            chk(sel_tag(s2, mr, en & 1, wr, en >> 1), fwd_b,
                exp_sel(s2, mr, en & 1, wr, en >> 1));
          end

    // High register numbers beyond the sweep
    e_rs1 = 5'd31; e_rs2 = 5'd30; m_rd = 5'd31; w_rd = 5'd30; m_wen = 1; w_wen = 1;
    settle();
    chk("R1 high reg a", fwd_a, 2);
    chk("R2 high reg b", fwd_b, 1);
    e_rs1 = '0; e_rs2 = '0; m_rd = '0; w_rd = '0; m_wen = 0; w_wen = 0;

    // Stall and flush sweep: R6 R7 R8
    for (int rd = 0; rd < 4; rd++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            int st, fd, fe;
            e_rd = AW'(rd); d_rs1 = AW'(a); d_rs2 = AW'(b);
            e_is_load = c[0]; e_redirect = c[1];
            settle();
            st = (c[0] && (rd == a || rd == b)) ? 1 : 0;
            fd = c[1] ? 1 : 0;
            fe = (st == 1 || c[1]) ? 1 : 0;
            if (st == 1) begin
              chk("R6 stall_f", stall_f, 1);
              chk("R6 stall_d", stall_d, 1);
            end else begin
              chk("R7 stall_f", stall_f, 0);
              chk("R7 stall_d", stall_d, 0);
            end
            chk("R8 flush_d", flush_d, fd);
            chk(st == 1 ? "R6 flush_e" : "R8 flush_e", flush_e, fe);
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule